// File: doc/BRIEF.md
# Concurrent Observer Register Bank

This block is a bank of storage cells that sits in front of a combinational logic cone and doubles as that cone's test hardware. Each cell carries one system bit, which captures the cone's input data every clock, and one test bit, which keeps state of its own. Four control inputs pick the job of the test bits. They can shift a serial chain, generate patterns, or compress responses. The system bits can also be turned into a shift chain or a pattern generator for off-line testing.

For on-line testing, one bank acts as the generator in front of a cone, and a second bank sits behind the cone as its compressor. The generator compares its test bits with the live system bits. When the two match, it raises `hit_out` and moves to its next pattern. The compressor folds the cone's output into its signature only when its `hit_in` is high. After the generator has visited every pattern, the signature can be shifted out while normal operation continues.

The next-state function is a shift-left feedback register. A fixed tap mask gives a maximal-length linear sequence, and one extra nonlinear term splices the all-zero state into that sequence. One pass therefore covers all 2^W values.

Top module: `observer_bank`

## Requirements
- R1: After reset, both the system bits and the test bits are all zero. `par_out` reads 0, and the test bits read back 0 through the test chain.
- R2: In every mode except the two system-chain modes (`sel_sys`=1 with `sel_tst`=1), the system bits load `par_in` at each clock. `par_out` always shows the system bits.
- R3: System scan (`sel_sys`=1, `sel_tst`=1, `fb_open`=1) shifts the system bits one place toward the MSB, with `scan_in` entering bit 0. `scan_out` shows system bit W-1 whenever `sel_sys`=1. The test bits hold.
- R4: System pattern generation (`sel_sys`=1, `sel_tst`=1, `fb_open`=0) replaces the system bits with their feedback successor every clock. The test bits hold.
- R5: Test scan (`sel_sys`=0, `sel_tst`=0, `fb_open`=1, `hit_force`=1) shifts the test bits toward the MSB, with `scan_in` entering bit 0. `scan_out` shows test bit W-1 whenever `sel_sys`=0.
- R6: On-line generation (all four controls 0) drives `hit_out`=1 exactly when the test bits equal the current system bits. On a match the test bits advance to their feedback successor. Otherwise they hold.
- R7: `hit_out` is 0 in every mode other than on-line generation.
- R8: Compression (`sel_sys`=0, `sel_tst`=1, `fb_open`=0) sets the test bits to successor(test bits) XOR `par_in` when `hit_force`=1 or `hit_in`=1. When both are 0, the test bits hold.
- R9: The remaining control combinations leave the test bits unchanged.
- R10: The successor of state s is {s[W-2:0], f}. Here f is the XOR of the bits of s selected by TAPS, inverted when s[W-2:0] is all zero. The value 0 steps to 1, the value with only the MSB set steps to 0, and 2^W steps visit every value once and return to the start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_sys | input | 1 | Control: route the system bits into a chain |
| sel_tst | input | 1 | Control: test-chain / compressor select |
| fb_open | input | 1 | Control: 1 opens the feedback (plain scan), 0 closes it |
| hit_force | input | 1 | Control: forces compression every cycle; also qualifies test scan |
| hit_in | input | 1 | Match indication from the upstream generator bank |
| scan_in | input | 1 | Serial chain input |
| par_in | input | W | Parallel system data in |
| par_out | output | W | System bits |
| scan_out | output | 1 | Serial chain output |
| hit_out | output | 1 | Match indication to the downstream compressor bank |

## Verification
The bench builds the bank with W=8 and tap mask 8'hB8. This makes the complete 256-state generator cycle short enough to run end to end. It checks that every value appears once and that the start state returns after exactly 256 steps. At this width, driving the parallel input with the predicted test bits produces on-line matches often enough to exercise the advance-on-hit path many times. Random stretches cover all sixteen control combinations and give compression cycles both with and without the upstream match.

// File: rtl/obs_pkg.sv
package obs_pkg;
  typedef enum logic [2:0] {
    M_IDLE     = 3'd0,
    M_SYS_SCAN = 3'd1,
    M_SYS_GEN  = 3'd2,
    M_TST_SCAN = 3'd3,
    M_ONL_GEN  = 3'd4,
    M_CMP      = 3'd5
  } obs_mode_e;
endpackage

// File: rtl/obs_mode_dec.sv
module obs_mode_dec
  import obs_pkg::*;
(
  input  logic      sel_sys,
  input  logic      sel_tst,
  input  logic      fb_open,
  input  logic      hit_force,
  output obs_mode_e mode
);
  always_comb begin
    mode = M_IDLE;
    if (sel_sys && sel_tst)
      mode = fb_open ? M_SYS_SCAN : M_SYS_GEN;
    else if (!sel_sys && !sel_tst) begin
      if (fb_open && hit_force)        mode = M_TST_SCAN;
      else if (!fb_open && !hit_force) mode = M_ONL_GEN;
    end else if (!sel_sys && sel_tst && !fb_open)
      mode = M_CMP;
  end
endmodule

// File: rtl/obs_feedback.sv
module obs_feedback #(
  parameter int          W    = 8,
  parameter logic [W-1:0] TAPS = 8'hB8
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt
);
  logic [W-1:0] tapped;
  logic         lin_bit;
  logic         low_zero;

  for (genvar i = 0; i < W; i++) begin : g_tap
    if (TAPS[i]) begin : g_on
      assign tapped[i] = cur[i];
    end else begin : g_off
      assign tapped[i] = 1'b0;
    end
  end

  assign lin_bit  = ^tapped;
  assign low_zero = (cur[W-2:0] == '0);
  assign nxt      = {cur[W-2:0], lin_bit ^ low_zero};
endmodule

// File: rtl/obs_hit_unit.sv
module obs_hit_unit
  import obs_pkg::*;
#(
  parameter int W = 8
) (
  input  obs_mode_e    mode,
  input  logic [W-1:0] test_q,
  input  logic [W-1:0] sys_q,
  input  logic         hit_in,
  input  logic         hit_force,
  output logic         hit_out,
  output logic         step_en
);
  logic [W-1:0] bit_eq;
  logic         match;

  for (genvar i = 0; i < W; i++) begin : g_cmp
    assign bit_eq[i] = ~(test_q[i] ^ sys_q[i]);
  end

  assign match = &bit_eq;

  always_comb begin
    hit_out = 1'b0;
    step_en = 1'b0;
    case (mode)
      M_ONL_GEN: begin
        hit_out = match;
        step_en = match;
      end
      M_CMP:   step_en = hit_force | hit_in;
      default: ;
    endcase
  end
endmodule

// File: rtl/observer_bank.sv
module observer_bank
  import obs_pkg::*;
#(
  parameter int          W    = 8,
  parameter logic [W-1:0] TAPS = 8'hB8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel_sys,
  input  logic         sel_tst,
  input  logic         fb_open,
  input  logic         hit_force,
  input  logic         hit_in,
  input  logic         scan_in,
  input  logic [W-1:0] par_in,
  output logic [W-1:0] par_out,
  output logic         scan_out,
  output logic         hit_out
);
  localparam int MSB = W - 1;

  obs_mode_e    mode;
  logic [W-1:0] sys_q, sys_d, sys_step;
  logic [W-1:0] test_q, test_d, test_step;
  logic         step_en;

  obs_mode_dec u_dec (
    .sel_sys   (sel_sys),
    .sel_tst   (sel_tst),
    .fb_open   (fb_open),
    .hit_force (hit_force),
    .mode      (mode)
  );

  obs_feedback #(.W(W), .TAPS(TAPS)) u_fb_sys (
    .cur (sys_q),
    .nxt (sys_step)
  );

  obs_feedback #(.W(W), .TAPS(TAPS)) u_fb_test (
    .cur (test_q),
    .nxt (test_step)
  );

  obs_hit_unit #(.W(W)) u_hit (
    .mode      (mode),
    .test_q    (test_q),
    .sys_q     (sys_q),
    .hit_in    (hit_in),
    .hit_force (hit_force),
    .hit_out   (hit_out),
    .step_en   (step_en)
  );

  always_comb begin
    case (mode)
      M_SYS_SCAN: sys_d = {sys_q[MSB-1:0], scan_in};
      M_SYS_GEN:  sys_d = sys_step;
      default:    sys_d = par_in;
    endcase
  end

  always_comb begin
    test_d = test_q;
    case (mode)
      M_TST_SCAN: test_d = {test_q[MSB-1:0], scan_in};
      M_ONL_GEN:  if (step_en) test_d = test_step;
      M_CMP:      if (step_en) test_d = test_step ^ par_in;
      default:    ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_q  <= '0;
      test_q <= '0;
    end else begin
      sys_q  <= sys_d;
      test_q <= test_d;
    end
  end

  assign par_out  = sys_q;
  assign scan_out = sel_sys ? sys_q[MSB] : test_q[MSB];
endmodule

// File: rtl/observer_bank_chk.sv
module observer_bank_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sel_sys,
  input logic         sel_tst,
  input logic         fb_open,
  input logic         hit_force,
  input logic         hit_in,
  input logic         scan_in,
  input logic [W-1:0] par_in,
  input logic [W-1:0] par_out,
  input logic         hit_out,
  input logic [W-1:0] test_q
);
  logic sys_chain, onl_gen, tst_scan, cmp_mode;
  assign sys_chain = sel_sys && sel_tst;
  assign onl_gen   = !sel_sys && !sel_tst && !fb_open && !hit_force;
  assign tst_scan  = !sel_sys && !sel_tst && fb_open && hit_force;
  assign cmp_mode  = !sel_sys && sel_tst && !fb_open;

  a_r2_par_load: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_chain |=> par_out == $past(par_in));

  a_r3_sys_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_chain && fb_open) |=>
      (par_out[0] == $past(scan_in)) && (par_out[W-1:1] == $past(par_out[W-2:0])));

  a_r3_test_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sys_chain |=> $stable(test_q));

  a_r5_test_shift: assert property (@(posedge clk) disable iff (!rst_n)
    tst_scan |=> (test_q[0] == $past(scan_in)) && (test_q[W-1:1] == $past(test_q[W-2:0])));

  a_r6_miss_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (onl_gen && !hit_out) |=> $stable(test_q));

  a_r7_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !onl_gen |-> !hit_out);

  a_r8_cmp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_mode && !hit_force && !hit_in) |=> $stable(test_q));

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_chain && !onl_gen && !tst_scan && !cmp_mode) |=> $stable(test_q));

  a_r10_zero_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_chain && !fb_open && par_out == '0) |=> par_out == {{(W-1){1'b0}}, 1'b1});
endmodule

bind observer_bank observer_bank_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel_sys   (sel_sys),
  .sel_tst   (sel_tst),
  .fb_open   (fb_open),
  .hit_force (hit_force),
  .hit_in    (hit_in),
  .scan_in   (scan_in),
  .par_in    (par_in),
  .par_out   (par_out),
  .hit_out   (hit_out),
  .test_q    (test_q)
);

// File: tb/observer_bank_tb_top.sv
`timescale 1ns/1ps
module observer_bank_tb_top;
  localparam int          W    = 8;
  localparam logic [W-1:0] TAPS = 8'hB8;
  localparam int          N    = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sel_sys = 0, sel_tst = 0, fb_open = 0, hit_force = 0, hit_in = 0, scan_in = 0;
  logic [W-1:0] par_in = '0;
  logic [W-1:0] par_out;
  logic         scan_out, hit_out;

  int n_checks = 0;
  int n_fail   = 0;
  logic [W-1:0] sys_m  = '0;
  logic [W-1:0] test_m = '0;

  always #10 clk = ~clk;

  observer_bank #(.W(W), .TAPS(TAPS)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel_sys(sel_sys), .sel_tst(sel_tst),
    .fb_open(fb_open), .hit_force(hit_force), .hit_in(hit_in),
    .scan_in(scan_in), .par_in(par_in), .par_out(par_out),
    .scan_out(scan_out), .hit_out(hit_out)
  );

  function automatic logic [W-1:0] ref_next(input logic [W-1:0] s);
    int ones = 0;
    for (int i = 0; i < W; i++)
      if (TAPS[i] && s[i]) ones++;
    if ((int'(s) % (N / 2)) == 0) ones++;
    return W'((int'(s) * 2 + (ones % 2)) % N);
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic s, input logic t, input logic o, input logic f,
                     input logic hin, input logic sin, input logic [W-1:0] din);
    logic gen, tsc, cmp, ssc, sgn, exp_hit;
    logic [W-1:0] nsys, ntest;
    sel_sys = s; sel_tst = t; fb_open = o; hit_force = f;
    hit_in = hin; scan_in = sin; par_in = din;
    gen = !s && !t && !o && !f;
    tsc = !s && !t && o && f;
    cmp = !s && t && !o;
    ssc = s && t && o;
    sgn = s && t && !o;
    #1;
    exp_hit = gen && (test_m == sys_m);
    check(hit_out == exp_hit, gen ? "R6 hit_out" : "R7 hit_out", int'(hit_out), int'(exp_hit));
    @(posedge clk);
    if (ssc)      nsys = {sys_m[W-2:0], sin};
    else if (sgn) nsys = ref_next(sys_m);
    else          nsys = din;
    ntest = test_m;
    if (tsc)                   ntest = {test_m[W-2:0], sin};
    else if (gen && exp_hit)   ntest = ref_next(test_m);
    else if (cmp && (f || hin)) ntest = ref_next(test_m) ^ din;
    sys_m = nsys; test_m = ntest;
    @(negedge clk);
    check(par_out == sys_m, ssc ? "R3 par_out" : (sgn ? "R4 par_out" : "R2 par_out"),
          int'(par_out), int'(sys_m));
    check(scan_out == (s ? sys_m[W-1] : test_m[W-1]),
          s ? "R3 scan_out" : (tsc ? "R5 scan_out" : (cmp ? "R8 scan_out" : "R9 scan_out")),
          int'(scan_out), int'(s ? sys_m[W-1] : test_m[W-1]));
  endtask

  initial begin
    #(200000 * 20);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] tv, start;
    bit seen [N];
    int distinct;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check(par_out == '0, "R1 par_out", int'(par_out), 0);
    check(scan_out == 1'b0, "R1 scan_out", int'(scan_out), 0);
    // R1 test bits read out through test scan
    for (int i = 0; i < W; i++) cyc(0, 0, 1, 1, 0, 0, W'($urandom));

    // R5 load test bits serially
    tv = 8'hC5;
    for (int i = W - 1; i >= 0; i--) cyc(0, 0, 1, 1, 0, tv[i], W'($urandom));
    check(test_m == tv, "R5 loaded pattern", int'(test_m), int'(tv));

    // R6 on-line generation: alternate matching and non-matching data
    for (int i = 0; i < 60; i++)
      cyc(0, 0, 0, 0, 0, 0, (i % 3 != 2) ? test_m : W'($urandom));

    // R8 compression, forced and qualified by upstream match
    for (int i = 0; i < 20; i++) cyc(0, 1, 0, 1, 0, 0, W'($urandom));
    for (int i = 0; i < 30; i++) cyc(0, 1, 0, 0, i[0], 0, W'($urandom));

    // R9 idle combinations
    cyc(1, 0, 0, 0, 1, 1, W'($urandom));
    cyc(1, 0, 1, 1, 1, 0, W'($urandom));
    cyc(0, 1, 1, 0, 1, 1, W'($urandom));
    cyc(0, 0, 1, 0, 1, 1, W'($urandom));
    cyc(0, 0, 0, 1, 1, 0, W'($urandom));

    // R3 system scan loads a start value
    tv = 8'h80;
    for (int i = W - 1; i >= 0; i--) cyc(1, 1, 1, 0, 0, tv[i], W'($urandom));
    check(par_out == 8'h80, "R3 scanned value", int'(par_out), 8'h80);
    // R10 MSB-only steps to zero, zero steps to one
    cyc(1, 1, 0, 0, 0, 0, '0);
    check(par_out == '0, "R10 msb to zero", int'(par_out), 0);
    cyc(1, 1, 0, 0, 0, 0, '0);
    check(par_out == 8'h01, "R10 zero to one", int'(par_out), 1);

    // R4/R10 full cycle from an arbitrary start
    start = par_out;
    for (int i = 0; i < N; i++) seen[i] = 0;
    distinct = 0;
    for (int i = 0; i < N; i++) begin
      if (!seen[par_out]) distinct++;
      seen[par_out] = 1;
      cyc(1, 1, 0, 0, 0, 0, W'($urandom));
    end
    check(distinct == N, "R10 distinct states", distinct, N);
    check(par_out == start, "R10 period return", int'(par_out), int'(start));

    // mixed random traffic over all control combinations
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] c;
      c = 4'($urandom);
      cyc(c[3], c[2], c[1], c[0], 1'($urandom), 1'($urandom),
          ($urandom % 2) ? test_m : W'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule